// File: doc/BRIEF.md
# Duty-Cycled Bipolar Magnetic Latch Controller

This block sequences a magnetic pole sensor front end that runs on a duty cycle, and it holds the latched pole state that the sensor reports. A free-running interval timer alternates between an awake window and a sleep window. The front end is powered and asked for a sample only during the awake window, and it is off during the sleep window. The first valid signed flux sample of each awake window is compared against two thresholds. A sample above the positive operate level (S pole) sets the latch. A sample below the negative release level (N pole) clears it. A sample anywhere in the band between the two levels leaves the latch as it was.

A low enable puts the block into power-down. The front-end request drops, the output is marked not valid, and the latched level is frozen. When enable returns high, the latch restarts in the released state and an awake window opens at once. The output is marked valid again only after a fresh sample has been evaluated. A polarity input selects whether the S-pole-detected state drives the output high or low. Thresholds and window lengths are parameters counted in clock ticks. If the sleep length is set to zero, the block samples continuously.

Top module: `duty_latch`

## Requirements
- R1: While reset is asserted, fe_on is 1, out_valid is 0, and the latch is released, so out_level equals the inverse of pol_high.
- R2: With enable high, fe_on is high for exactly AWAKE_TICKS consecutive cycles and then low for exactly SLEEP_TICKS consecutive cycles, and this pattern repeats.
- R3: A sample taken while fe_on is high that is strictly greater than OP_LEVEL puts the latch in the detected state on the next clock edge. A sample equal to OP_LEVEL does not set the latch.
- R4: A sample taken while fe_on is high that is strictly less than REL_LEVEL puts the latch in the released state on the next clock edge. A sample equal to REL_LEVEL does not clear the latch.
- R5: A sample with REL_LEVEL <= sample <= OP_LEVEL leaves the latch state unchanged.
- R6: Only the first valid sample of each awake window is evaluated. Later samples in the same window, and samples offered while fe_on is low, have no effect.
- R7: out_level equals the latch state when pol_high is 1 and its inverse when pol_high is 0 (detected = 1). The input acts combinationally.
- R8: One clock edge after enable is seen low, fe_on and out_valid are 0 and out_level keeps its value. Samples offered during power-down have no effect.
- R9: On the first clock edge with enable high after power-down, the latch is released, fe_on rises and out_valid stays 0. out_valid rises on the edge that evaluates the first sample of that window.
- R10: With SLEEP_TICKS = 0, fe_on stays high continuously and a new sample is evaluated in every AWAKE_TICKS window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | 1 = operate, 0 = power-down |
| pol_high | input | 1 | 1 = output high when S pole detected, 0 = low |
| sample_valid | input | 1 | Strobe marking a sample on the sample input |
| sample | input | SAMPLE_W | Signed flux sample, positive = S pole |
| fe_on | output | 1 | Front-end power and sample request |
| out_level | output | 1 | Latched pole output after polarity selection |
| out_valid | output | 1 | A fresh evaluation has happened since wake-up |

## Verification
The embedded properties assume that pol_high is held steady while the latch state is checked. They also assume that a sample strobe has meaning only while fe_on is high, so any strobe outside the awake window is expected to be discarded. The directed stimulus changes inputs only on falling clock edges. It waits until a fresh awake window has been seen to open before it offers a sample, and it places deliberate extra strobes either inside a window that is already in use or while fe_on is low. Continuous sampling is exercised on a second instance, where successive samples are spaced more than one awake window apart.

// File: rtl/duty_latch.sv
module duty_latch #(
  parameter int SAMPLE_W    = 12,
  parameter int AWAKE_TICKS = 8,
  parameter int SLEEP_TICKS = 20,
  parameter int OP_LEVEL    = 30,
  parameter int REL_LEVEL   = -30
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic                       pol_high,
  input  logic                       sample_valid,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic                       fe_on,
  output logic                       out_level,
  output logic                       out_valid
);
  localparam int MAXT  = (AWAKE_TICKS > SLEEP_TICKS) ? AWAKE_TICKS : SLEEP_TICKS;
  localparam int CNT_W = $clog2(MAXT + 1);
  localparam logic [CNT_W-1:0] A_LAST = CNT_W'(AWAKE_TICKS - 1);
  localparam logic [CNT_W-1:0] S_LAST = CNT_W'((SLEEP_TICKS > 0) ? SLEEP_TICKS - 1 : 0);
  localparam logic signed [SAMPLE_W-1:0] OP_Q  = SAMPLE_W'(OP_LEVEL);
  localparam logic signed [SAMPLE_W-1:0] REL_Q = SAMPLE_W'(REL_LEVEL);

  typedef enum logic [1:0] {PH_AWAKE, PH_SLEEP, PH_OFF} phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             taken, det, valid_q;
  logic             take;

  assign fe_on     = (phase == PH_AWAKE);
  assign take      = fe_on && sample_valid && !taken;
  assign out_level = pol_high ? det : ~det;
  assign out_valid = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_AWAKE;
      cnt     <= '0;
      taken   <= 1'b0;
      det     <= 1'b0;
      valid_q <= 1'b0;
    end else if (!enable) begin
      phase   <= PH_OFF;
      cnt     <= '0;
      taken   <= 1'b0;
      valid_q <= 1'b0;
    end else if (phase == PH_OFF) begin
      phase <= PH_AWAKE;
      cnt   <= '0;
      taken <= 1'b0;
      det   <= 1'b0;
    end else begin
      if (take) begin
        taken   <= 1'b1;
        valid_q <= 1'b1;
        if (sample > OP_Q)       det <= 1'b1;
        else if (sample < REL_Q) det <= 1'b0;
      end
      if (phase == PH_AWAKE) begin
        if (cnt == A_LAST) begin
          cnt   <= '0;
          taken <= 1'b0;
          phase <= (SLEEP_TICKS == 0) ? PH_AWAKE : PH_SLEEP;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cnt == S_LAST) begin
          cnt   <= '0;
          phase <= PH_AWAKE;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_op_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && take && sample > OP_Q) |=> det);

  p_rel_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && take && sample < REL_Q) |=> !det);

  p_band_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && phase != PH_OFF && !(take && (sample > OP_Q || sample < REL_Q))) |=> $stable(det));

  p_awake_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fe_on |-> (cnt <= A_LAST));

  p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!fe_on && !out_valid && $stable(det)));

  p_valid_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(fe_on && sample_valid && enable));

  p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && phase == PH_OFF) |=> (fe_on && !det && !out_valid));
endmodule

// File: tb/sim_duty_latch.sv
module sim_duty_latch;
  localparam int W = 12;
  localparam int A = 8;
  localparam int S = 20;
  localparam int OP = 30;
  localparam int REL = -30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic pol_high = 1'b0;
  logic sv0 = 1'b0, sv1 = 1'b0;
  logic signed [W-1:0] sample = '0;
  logic fe_on, out_level, out_valid;
  logic fe_on1, out_level1, out_valid1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  duty_latch #(.SAMPLE_W(W), .AWAKE_TICKS(A), .SLEEP_TICKS(S), .OP_LEVEL(OP), .REL_LEVEL(REL)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pol_high(pol_high), .sample_valid(sv0),
    .sample(sample), .fe_on(fe_on), .out_level(out_level), .out_valid(out_valid));

  duty_latch #(.SAMPLE_W(W), .AWAKE_TICKS(A), .SLEEP_TICKS(0), .OP_LEVEL(OP), .REL_LEVEL(REL)) u1 (
    .clk(clk), .rst_n(rst_n), .enable(1'b1), .pol_high(pol_high), .sample_valid(sv1),
    .sample(sample), .fe_on(fe_on1), .out_level(out_level1), .out_valid(out_valid1));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lvl(int det_v);
    return pol_high ? det_v : 1 - det_v;
  endfunction

  task automatic next_window();
    @(negedge clk);
    while (fe_on) @(negedge clk);
    while (!fe_on) @(negedge clk);
  endtask

  task automatic offer(int v);
    sample = W'(v);
    sv0 = 1'b1;
    @(negedge clk);
    sv0 = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 fe_on", fe_on, 1);
    check("R1 out_valid", out_valid, 0);
    check("R1 out_level", out_level, lvl(0));
    rst_n = 1'b1;
  endtask

  task automatic t_period();
    int hi = 0, lo = 0;
    next_window();
    while (fe_on) begin hi++; @(negedge clk); end
    while (!fe_on) begin lo++; @(negedge clk); end
    check("R2 awake length", hi, A);
    check("R2 sleep length", lo, S);
  endtask

  task automatic t_thresholds();
    next_window(); offer(OP);
    check("R3 equal to operate holds", out_level, lvl(0));
    check("R9 valid after first sample", out_valid, 1);
    next_window(); offer(OP + 1);
    check("R3 above operate sets", out_level, lvl(1));
    next_window(); offer(0);
    check("R5 band holds set", out_level, lvl(1));
    next_window(); offer(REL);
    check("R4 equal to release holds", out_level, lvl(1));
    next_window(); offer(REL - 1);
    check("R4 below release clears", out_level, lvl(0));
    next_window(); offer(OP - 1);
    check("R5 band holds clear", out_level, lvl(0));
  endtask

  task automatic t_first_only();
    next_window(); offer(100);
    offer(-100);
    check("R6 second sample in window ignored", out_level, lvl(1));
    while (fe_on) @(negedge clk);
    offer(-100);
    check("R6 sample while asleep ignored", out_level, lvl(1));
  endtask

  task automatic t_polarity();
    pol_high = 1'b1; #1;
    check("R7 high polarity detected", out_level, 1);
    pol_high = 1'b0; #1;
    check("R7 low polarity detected", out_level, 0);
  endtask

  task automatic t_powerdown();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R8 fe_on off", fe_on, 0);
    check("R8 valid off", out_valid, 0);
    check("R8 level held", out_level, lvl(1));
    offer(-100);
    repeat (3) @(negedge clk);
    check("R8 sample ignored in power-down", out_level, lvl(1));
    check("R8 fe_on stays off", fe_on, 0);
    enable = 1'b1;
    @(negedge clk);
    check("R9 fe_on on wake", fe_on, 1);
    check("R9 released on wake", out_level, lvl(0));
    check("R9 not valid before sample", out_valid, 0);
    offer(50);
    check("R9 valid after fresh sample", out_valid, 1);
    check("R9 fresh sample evaluated", out_level, lvl(1));
  endtask

  task automatic t_continuous();
    int low_seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (!fe_on1) low_seen++;
    end
    check("R10 fe_on continuous", low_seen, 0);
    sample = W'(80); sv1 = 1'b1;
    @(negedge clk); sv1 = 1'b0;
    check("R10 set", out_level1, lvl(1));
    repeat (A) @(negedge clk);
    sample = W'(-80); sv1 = 1'b1;
    @(negedge clk); sv1 = 1'b0;
    check("R10 next window evaluated", out_level1, lvl(0));
  endtask

  initial begin
    t_reset();
    t_period();
    t_thresholds();
    t_first_only();
    t_polarity();
    t_powerdown();
    t_continuous();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule